// File: doc/BRIEF.md
# Table-Driven Setpoint Edge Generator

This block shapes the power setpoint fed to a control loop so that a pulse edge follows a stored profile instead of jumping in one step. It keeps two profile tables, one for rising edges and one for falling edges. Each table holds 256 normalized 16-bit scale factors, where 0x0000 stands for none of the amplitude and 0xFFFF for all of it. Software fills both tables through a simple write port before use.

A single start command picks one table, and playback begins at entry 0. Each pulse on the tick input, normally the 250 kHz loop strobe, fetches the next entry from a synchronous RAM. The entry is multiplied by the amplitude sampled on that tick, and the upper half of the product is presented as the setpoint together with a one-cycle valid strobe. A 256-entry edge therefore lasts about 1 ms. Once the last entry has been fetched, the block stops advancing and holds that steady-state value until the next start. A start issued during playback abandons the running edge and begins again at entry 0 of the newly named table.

Top module: `edge_setpoint_gen`

## Requirements
- R1: While rst_n is low at a clock edge, the block clears itself. After that edge, setpoint is 0, setpoint_valid is 0 and busy is 0.
- R2: A write with wr_en high stores wr_data at wr_addr in one table only. wr_tbl selects the table: 0 is the rising table and 1 is the falling table. The other table is left unchanged.
- R3: A start pulse with start_tbl selects the table (0 is rising, 1 is falling). In the cycle after the start pulse, busy is 1 and playback points at entry 0. A tick in the same cycle as start is ignored and produces no valid strobe.
- R4: Each tick while busy fetches the next table entry, in address order 0, 1, …, 255. Exactly one cycle after that tick, setpoint_valid is 1. setpoint_valid is 0 in every other cycle.
- R5: The setpoint shown with each valid strobe is bits 31:16 of the product of the fetched entry and the amplitude present on the tick.
- R6: The tick that fetches entry 255 ends playback, and busy is 0 from the next cycle. Ticks after that produce no valid strobe, and setpoint keeps the value from entry 255.
- R7: A start during playback restarts at entry 0 of the table named by the new start_tbl. The next tick fetches that entry.
- R8: Ticks before any start produce no valid strobe and leave setpoint unchanged.
- R9: Changing amplitude between ticks leaves setpoint unchanged until the next tick fetches an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Table write strobe |
| wr_tbl | input | 1 | Table to write: 0 is rising, 1 is falling |
| wr_addr | input | 8 | Entry address to write |
| wr_data | input | 16 | Normalized scale factor to store |
| amplitude | input | 16 | Full-scale setpoint amplitude, sampled on each fetching tick |
| start | input | 1 | Begin an edge (or restart one) |
| start_tbl | input | 1 | Table to play: 0 is rising, 1 is falling |
| tick | input | 1 | Loop strobe; each one advances playback by one entry |
| setpoint | output | 16 | Scaled setpoint |
| setpoint_valid | output | 1 | One-cycle strobe marking a freshly fetched setpoint |
| busy | output | 1 | High from a start until the last entry is fetched |

## Verification
A start takes effect at the next edge, so busy is sampled one cycle after the start pulse. Each fetching tick passes through one RAM read register, and the amplitude capture sits beside it. The valid strobe and the new setpoint are therefore sampled exactly one cycle after the tick, and busy is checked in that same cycle. The bench drives inputs on the falling clock edge and samples on the next falling edge, so every result is read in the cycle the requirement names. Cycles with no fetch check that valid stays low and that setpoint keeps its last value, even when amplitude changes or extra ticks arrive.

// File: rtl/edgegen_pkg.sv
`timescale 1ns/1ps
// Package: shared types and helpers for the setpoint edge generator.
// Assumes a table selector of one bit (two tables).
package edgegen_pkg;

    // Which profile table is addressed.
    typedef enum logic {
        TBL_RISE = 1'b0,
        TBL_FALL = 1'b1
    } tbl_e;

    // Number of profile tables held by the block.
    localparam int unsigned NUM_TBL = 2;

endpackage

// File: rtl/edge_table_ram.sv
`timescale 1ns/1ps
// Module: edge_table_ram
// One profile table: a single write port and a registered read port.
// Assumes read-first behaviour. When a read and a write hit the same
// address in one cycle, the read returns the old word. The storage
// array has no reset. Only the read register is cleared by reset.
module edge_table_ram #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store one word on each write strobe.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Registered read; the output holds between read strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= mem[raddr];
        end
    end

    // R4: the read register only changes on a read strobe.
    a_r4_rdata_holds_without_read: assert property (
        @(posedge clk) disable iff (!rst_n)
        !re |=> $stable(rdata)
    );

endmodule

// File: rtl/edge_sequencer.sv
`timescale 1ns/1ps
// Module: edge_sequencer
// Playback control. It steps an address through the selected table,
// one entry per tick, and stops after the last entry. Start has
// priority over a tick in the same cycle and always restarts at
// address 0. Assumes tick and start are single-cycle strobes in the
// clk domain.
module edge_sequencer
    import edgegen_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  tbl_e              start_tbl,
    input  logic              tick,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output tbl_e              rd_tbl,
    output logic              data_valid,
    output tbl_e              data_tbl,
    output logic              busy
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

    logic [ADDR_W-1:0] ptr_q;
    tbl_e              tbl_q;
    logic              run_q;

    // A fetch happens on a tick while playing, unless a start overrides it.
    always_comb begin
        rd_en   = run_q && tick && !start;
        rd_addr = ptr_q;
        rd_tbl  = tbl_q;
        busy    = run_q;
    end

    // Address, table and run state of the playback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            tbl_q <= TBL_RISE;
            run_q <= 1'b0;
        end else if (start) begin
            ptr_q <= '0;
            tbl_q <= start_tbl;
            run_q <= 1'b1;
        end else if (rd_en) begin
            if (ptr_q == LAST_ADDR) begin
                run_q <= 1'b0;
            end else begin
                ptr_q <= ptr_q + 1'b1;
            end
        end
    end

    // Valid strobe and table tag aligned with the RAM output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_valid <= 1'b0;
            data_tbl   <= TBL_RISE;
        end else begin
            data_valid <= rd_en;
            if (rd_en) begin
                data_tbl <= tbl_q;
            end
        end
    end

    // R3: a start makes the block busy at entry 0.
    a_r3_start_sets_busy: assert property (
        @(posedge clk) disable iff (!rst_n)
        start |=> (busy && rd_addr == '0)
    );

    // R3: a tick coinciding with start fetches nothing.
    a_r3_start_blocks_tick: assert property (
        @(posedge clk) disable iff (!rst_n)
        start |-> !rd_en
    );

    // R4: valid follows a fetch by exactly one cycle.
    a_r4_valid_after_fetch: assert property (
        @(posedge clk) disable iff (!rst_n)
        rd_en |=> data_valid
    );

    // R4: no valid without a fetch in the cycle before.
    a_r4_no_stray_valid: assert property (
        @(posedge clk) disable iff (!rst_n)
        !rd_en |=> !data_valid
    );

    // R4: fetches walk the addresses upward one at a time.
    a_r4_addr_steps_by_one: assert property (
        @(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr != LAST_ADDR) |=> (rd_addr == $past(rd_addr) + 1'b1)
    );

    // R6: fetching the last entry ends playback.
    a_r6_last_fetch_clears_busy: assert property (
        @(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == LAST_ADDR) |=> !busy
    );

    // R8: nothing is fetched while idle.
    a_r8_idle_no_fetch: assert property (
        @(posedge clk) disable iff (!rst_n)
        !busy |-> !rd_en
    );

endmodule

// File: rtl/edge_scaler.sv
`timescale 1ns/1ps
// Module: edge_scaler
// Scales a normalized table entry by an amplitude. The amplitude is
// captured on the same strobe that loads the RAM read register, so the
// product stays fixed between fetches. The output is the upper AMP_W
// bits of the full product. Assumes entry comes from a register that
// updates on cap_en.
module edge_scaler #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned AMP_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [AMP_W-1:0]  amplitude,
    input  logic [DATA_W-1:0] entry,
    output logic [AMP_W-1:0]  setpoint
);
    localparam int unsigned PROD_W = DATA_W + AMP_W;

    logic [AMP_W-1:0]  amp_q;
    logic [PROD_W-1:0] prod;

    // Capture the amplitude that goes with the entry being fetched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            amp_q <= '0;
        end else if (cap_en) begin
            amp_q <= amplitude;
        end
    end

    // Full-width product, keep the upper part.
    always_comb begin
        prod     = PROD_W'(entry) * PROD_W'(amp_q);
        setpoint = prod[PROD_W-1 -: AMP_W];
    end

    // R5: a normalized factor never exceeds the amplitude.
    a_r5_setpoint_within_amplitude: assert property (
        @(posedge clk) disable iff (!rst_n)
        setpoint <= amp_q
    );

endmodule

// File: rtl/edge_setpoint_gen.sv
`timescale 1ns/1ps
// Module: edge_setpoint_gen (top)
// Holds a rising and a falling profile table. It plays the selected
// table one entry per tick after a start, scales each entry by the
// amplitude and holds the last entry once the edge is complete.
// Assumes single-cycle start and tick strobes and that software loads
// the tables before starting an edge.
module edge_setpoint_gen
    import edgegen_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned AMP_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_tbl,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AMP_W-1:0]  amplitude,
    input  logic              start,
    input  logic              start_tbl,
    input  logic              tick,
    output logic [AMP_W-1:0]  setpoint,
    output logic              setpoint_valid,
    output logic              busy
);
    logic              rd_en;
    logic [ADDR_W-1:0] rd_addr;
    tbl_e              rd_tbl;
    tbl_e              data_tbl;
    tbl_e              start_sel;
    logic [DATA_W-1:0] tbl_rdata [NUM_TBL];
    logic [DATA_W-1:0] entry;

    // Map the plain start selector onto the table type.
    always_comb begin
        start_sel = tbl_e'(start_tbl);
    end

    edge_sequencer #(
        .ADDR_W (ADDR_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_tbl  (start_sel),
        .tick       (tick),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .rd_tbl     (rd_tbl),
        .data_valid (setpoint_valid),
        .data_tbl   (data_tbl),
        .busy       (busy)
    );

    // One RAM per table, with write and read enables steered by selector.
    for (genvar t = 0; t < NUM_TBL; t++) begin : g_tbl
        logic we_t;
        logic re_t;

        // Steer the strobes to this table only.
        always_comb begin
            we_t = wr_en && (wr_tbl == 1'(t));
            re_t = rd_en && (rd_tbl == tbl_e'(t));
        end

        edge_table_ram #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W)
        ) u_ram (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (we_t),
            .waddr (wr_addr),
            .wdata (wr_data),
            .re    (re_t),
            .raddr (rd_addr),
            .rdata (tbl_rdata[t])
        );
    end

    // Pick the read register of the table fetched last.
    always_comb begin
        entry = tbl_rdata[data_tbl];
    end

    edge_scaler #(
        .DATA_W (DATA_W),
        .AMP_W  (AMP_W)
    ) u_scale (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (rd_en),
        .amplitude (amplitude),
        .entry     (entry),
        .setpoint  (setpoint)
    );

    // R6, R9: the setpoint only moves on a valid strobe.
    a_r9_setpoint_held_between_fetches: assert property (
        @(posedge clk) disable iff (!rst_n)
        !setpoint_valid |-> $stable(setpoint)
    );

    // R1: reset leaves the outputs cleared.
    a_r1_reset_clears: assert property (
        @(posedge clk)
        !rst_n |=> (setpoint == '0 && !setpoint_valid && !busy)
    );

endmodule

// File: tb/edge_setpoint_gen_tb.sv
`timescale 1ns/1ps
// Bench for edge_setpoint_gen. It uses seeded random tables and
// amplitudes plus directed corner cases. Inputs change on the falling
// edge, and outputs are sampled on the following falling edge.
module edge_setpoint_gen_tb;
    localparam int DEPTH = 256;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic        wr_tbl;
    logic [7:0]  wr_addr;
    logic [15:0] wr_data;
    logic [15:0] amplitude;
    logic        start;
    logic        start_tbl;
    logic        tick;
    logic [15:0] setpoint;
    logic        setpoint_valid;
    logic        busy;

    logic [15:0] model [2][DEPTH];
    int          n_tests = 0;
    int          n_fail  = 0;
    int          ptr     = 0;
    bit          cur_tbl = 0;
    bit          playing = 0;
    logic [15:0] last_sp = 16'h0;

    always #2.5 clk = ~clk;

    edge_setpoint_gen u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .wr_tbl         (wr_tbl),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .amplitude      (amplitude),
        .start          (start),
        .start_tbl      (start_tbl),
        .tick           (tick),
        .setpoint       (setpoint),
        .setpoint_valid (setpoint_valid),
        .busy           (busy)
    );

    function automatic logic [15:0] scale(logic [15:0] e, logic [15:0] a);
        logic [31:0] p;
        p = {16'h0, e} * {16'h0, a};
        return p[31:16];
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic write_entry(bit t, int a, logic [15:0] d);
        wr_en = 1'b1; wr_tbl = t; wr_addr = 8'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model[t][a] = d;
    endtask

    task automatic do_start(bit t, bit with_tick);
        start = 1'b1; start_tbl = t; tick = with_tick;
        @(negedge clk);
        start = 1'b0; tick = 1'b0;
        check("R3", "busy after start", 32'(busy), 32'd1);
        check("R3", "no valid from tick beside start", 32'(setpoint_valid), 32'd0);
        ptr = 0; cur_tbl = t; playing = 1;
    endtask

    task automatic do_tick(logic [15:0] amp, bit hold_check, string req);
        logic [15:0] exp_sp;
        amplitude = amp; tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        if (playing) begin
            exp_sp = scale(model[cur_tbl][ptr], amp);
            check("R4", "valid one cycle after tick", 32'(setpoint_valid), 32'd1);
            check(req, "scaled setpoint", 32'(setpoint), 32'(exp_sp));
            last_sp = exp_sp;
            if (ptr == DEPTH - 1) begin
                playing = 0;
                check("R6", "busy low after last entry", 32'(busy), 32'd0);
            end else begin
                check("R4", "busy during playback", 32'(busy), 32'd1);
                ptr++;
            end
        end else begin
            check(req, "no valid when not playing", 32'(setpoint_valid), 32'd0);
            check(req, "setpoint held", 32'(setpoint), 32'(last_sp));
        end
        if (hold_check) begin
            amplitude = 16'($urandom);
            @(negedge clk);
            check("R9", "setpoint held after amplitude change", 32'(setpoint), 32'(last_sp));
            check("R4", "valid low between ticks", 32'(setpoint_valid), 32'd0);
        end
    endtask

    initial begin
        #(200000 * 5);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; wr_en = 0; wr_tbl = 0; wr_addr = 0; wr_data = 0;
        amplitude = 16'hFFFF; start = 0; start_tbl = 0; tick = 0;
        repeat (3) @(negedge clk);
        // R1: outputs cleared by reset
        check("R1", "setpoint at reset", 32'(setpoint), 32'd0);
        check("R1", "valid at reset", 32'(setpoint_valid), 32'd0);
        check("R1", "busy at reset", 32'(busy), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: ticks before any start do nothing
        for (int i = 0; i < 3; i++) do_tick(16'($urandom), 1'b0, "R8");

        // Load both tables with random data and fixed corners
        for (int t = 0; t < 2; t++) begin
            for (int a = 0; a < DEPTH; a++) write_entry(t[0], a, 16'($urandom));
        end
        write_entry(0, 255, 16'hFFFF);
        write_entry(1, 0, 16'hFFFF);
        write_entry(1, 255, 16'h0000);

        // R2: rewrite rising entry 0; falling entry 0 must stay intact
        write_entry(0, 0, 16'h1234);
        do_start(1, 1'b0);
        do_tick(16'hFFFF, 1'b0, "R2");
        check("R2", "falling entry 0 untouched", 32'(setpoint), 32'h0000FFFE);
        do_start(0, 1'b0);
        do_tick(16'h8000, 1'b0, "R2");
        check("R2", "rising entry 0 written", 32'(setpoint), 32'h0000091A);

        // Full rising edge with a start that coincides with a tick
        do_start(0, 1'b1);
        for (int i = 0; i < DEPTH; i++) begin
            do_tick(16'($urandom), ($urandom % 4) == 0, "R5");
            repeat ($urandom % 3) begin
                @(negedge clk);
                check("R4", "valid low while idle between ticks", 32'(setpoint_valid), 32'd0);
            end
        end
        // R6: extra ticks after the last entry hold the value
        for (int i = 0; i < 3; i++) do_tick(16'($urandom), 1'b0, "R6");
        check("R6", "busy stays low", 32'(busy), 32'd0);

        // R7: restart mid-edge on the other table
        do_start(1, 1'b0);
        for (int i = 0; i < 20; i++) do_tick(16'($urandom), 1'b0, "R5");
        do_start(0, 1'b0);
        do_tick(16'hC000, 1'b0, "R7");
        check("R7", "restart fetched rising entry 0", 32'(setpoint), 32'(scale(16'h1234, 16'hC000)));

        // Full falling edge at full amplitude, ending on a zero entry
        do_start(1, 1'b0);
        for (int i = 0; i < DEPTH; i++) do_tick(16'hFFFF, ($urandom % 8) == 0, "R5");
        do_tick(16'h7777, 1'b0, "R6");
        check("R6", "held final zero entry", 32'(setpoint), 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule